// File: doc/BRIEF.md
# Receive Mailbox Status Tracker

This block holds the 4-bit status code of a single receive mailbox in a message-oriented serial bus controller. The matching engine signals the start and the end of each frame write into the mailbox. The CPU reads the control/status word, releases the mailbox with an unlock strobe and arms the mailbox by writing a code. The block turns these events into the code the CPU sees. That code covers inactive, empty, full and overrun, plus a transient busy bit in the least-significant position while a frame is being written.

A lock flag is set when the CPU reads the mailbox and cleared when it unlocks it. A completed read-then-unlock marks the stored frame as consumed. The next frame written after that counts as a fresh full buffer and not as an overrun. Payload storage, identifier matching and bus timing live elsewhere.

Top module: `mbx_rx_status`

## Requirements
- R1: After reset, `code_o` is 0000 (inactive) and `locked_o` is 0.
- R2: While the code is 0000, a store-start pulse is ignored: the code stays 0000 and never shows the busy bit.
- R3: An accepted store-start sets bit 0 of `code_o` from the next cycle until the cycle after the store-done pulse. Bits 3..1 keep their pre-store value during that time, so empty shows 0101, full shows 0011 and overrun shows 0111. The code does not change while busy unless store-done arrives.
- R4: A frame completed into an empty mailbox (code 0100) leaves the code at 0010 (full).
- R5: A frame completed into a full mailbox (0010) that was not read and then unlocked leaves the code at 0110 (overrun).
- R6: A frame completed into an overrun mailbox that was not read and then unlocked leaves the code at 0110.
- R7: If the CPU reads the mailbox and then unlocks it, the next completed frame sets a full or overrun mailbox to 0010. The consumed mark is then cleared, so the frame after that gives 0110 again.
- R8: A CPU read sets `locked_o` in the next cycle. An unlock without a read in the same cycle clears it in the next cycle. A frame completed while locked gives 0110 whenever the prior code was full or overrun.
- R9: A CPU code write takes effect in the next cycle only for the values 0000, 0100, 0010 and 0110. It is ignored while busy, in a cycle with a store-start pulse, and for any other value.
- R10: A store-start while already busy does not restart the store. A store-done while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| store_start_i | input | 1 | One-cycle pulse: matching engine begins writing a frame |
| store_done_i | input | 1 | One-cycle pulse: frame write finished |
| cpu_read_i | input | 1 | One-cycle pulse: CPU read of the control/status word |
| cpu_unlock_i | input | 1 | One-cycle pulse: CPU releases the mailbox |
| cpu_wr_i | input | 1 | CPU write strobe for the code |
| cpu_wr_code_i | input | 4 | Code value written by the CPU |
| code_o | output | 4 | Current status code including the busy bit |
| locked_o | output | 1 | Mailbox is locked by a CPU read |

## Verification
Every cycle, the assertions check the busy-bit window, the stability of the code while busy, the inactive state ignoring stores, the empty-to-full transition, and the set and clear timing of the lock flag. Whether a completed frame becomes full or overrun depends on the history of reads and unlocks since the previous frame. The directed read/unlock sequences and the randomized event mix, compared against a reference model, show that part. Ignored code writes, duplicate store-starts and stray store-dones are also covered only by bench scenarios.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_INACTIVE = 4'b0000;
    localparam logic [CODE_W-1:0] CODE_EMPTY    = 4'b0100;
    localparam logic [CODE_W-1:0] CODE_FULL     = 4'b0010;
    localparam logic [CODE_W-1:0] CODE_OVERRUN  = 4'b0110;

    typedef struct packed {
        logic [CODE_W-1:0] base;
        logic              busy;
    } code_state_t;

    typedef struct packed {
        logic locked;
        logic consumed;
    } lock_state_t;

    function automatic logic code_writable(input logic [CODE_W-1:0] c);
        return (c == CODE_INACTIVE) || (c == CODE_EMPTY) ||
               (c == CODE_FULL)     || (c == CODE_OVERRUN);
    endfunction
endpackage

// File: rtl/mbx_lock_trk.sv
module mbx_lock_trk
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic unlock_i,
    input  logic frame_done_i,
    output logic locked_o,
    output logic consumed_o
);
    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            st_d.locked = 1'b1;
        end else if (unlock_i) begin
            st_d.locked = 1'b0;
            // A read followed by an unlock releases the stored frame
            if (st_q.locked) st_d.consumed = 1'b1;
        end
        if (frame_done_i) st_d.consumed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked_o   = st_q.locked;
    assign consumed_o = st_q.consumed;
endmodule

// File: rtl/mbx_code_fsm.sv
module mbx_code_fsm
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              done_i,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              locked_i,
    input  logic              consumed_i,
    output logic [CODE_W-1:0] code_o,
    output logic              frame_done_o
);
    code_state_t st_d, st_q;
    logic        start_ok;
    logic        finish;
    logic        wr_ok;

    always_comb begin
        start_ok = start_i && !st_q.busy && (st_q.base != CODE_INACTIVE);
        finish   = done_i && st_q.busy;
        wr_ok    = wr_i && !st_q.busy && !start_i && code_writable(wr_code_i);

        st_d = st_q;
        if (start_ok) begin
            st_d.busy = 1'b1;
        end else if (finish) begin
            st_d.busy = 1'b0;
            if (st_q.base == CODE_EMPTY || (consumed_i && !locked_i))
                st_d.base = CODE_FULL;
            else
                st_d.base = CODE_OVERRUN;
        end else if (wr_ok) begin
            st_d.base = wr_code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{base: CODE_INACTIVE, busy: 1'b0};
        else        st_q <= st_d;
    end

    assign code_o       = {st_q.base[CODE_W-1:1], st_q.busy};
    assign frame_done_o = finish;
endmodule

// File: rtl/mbx_rx_status.sv
module mbx_rx_status
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_start_i,
    input  logic              store_done_i,
    input  logic              cpu_read_i,
    input  logic              cpu_unlock_i,
    input  logic              cpu_wr_i,
    input  logic [CODE_W-1:0] cpu_wr_code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              locked_o
);
    logic frame_done;
    logic consumed;

    mbx_lock_trk u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_i         (cpu_read_i),
        .unlock_i     (cpu_unlock_i),
        .frame_done_i (frame_done),
        .locked_o     (locked_o),
        .consumed_o   (consumed)
    );

    mbx_code_fsm u_code (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (store_start_i),
        .done_i       (store_done_i),
        .wr_i         (cpu_wr_i),
        .wr_code_i    (cpu_wr_code_i),
        .locked_i     (locked_o),
        .consumed_i   (consumed),
        .code_o       (code_o),
        .frame_done_o (frame_done)
    );
endmodule

// File: rtl/mbx_status_chk.sv
module mbx_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       store_start_i,
    input logic       store_done_i,
    input logic       cpu_read_i,
    input logic       cpu_unlock_i,
    input logic [3:0] code_o,
    input logic       locked_o
);
    // R2
    inactive_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == 4'b0000) |=> (code_o[0] == 1'b0));

    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_o[0] && !store_start_i) |=> !code_o[0]);

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o[0] && !store_done_i) |=> (code_o[0] && $stable(code_o)));

    // R3
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o[0] && store_done_i) |=> !code_o[0]);

    // R4
    empty_to_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == 4'b0101 && store_done_i) |=> (code_o == 4'b0010));

    // R8
    locked_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o[1] && code_o[0] && store_done_i && locked_o) |=> (code_o == 4'b0110));

    // R8
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_read_i |=> locked_o);

    // R8
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_unlock_i && !cpu_read_i) |=> !locked_o);
endmodule

bind mbx_rx_status mbx_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .store_start_i (store_start_i),
    .store_done_i  (store_done_i),
    .cpu_read_i    (cpu_read_i),
    .cpu_unlock_i  (cpu_unlock_i),
    .code_o        (code_o),
    .locked_o      (locked_o)
);

// File: tb/tb_mbx_rx_status.sv
module tb_mbx_rx_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       store_start_i = 1'b0;
    logic       store_done_i = 1'b0;
    logic       cpu_read_i = 1'b0;
    logic       cpu_unlock_i = 1'b0;
    logic       cpu_wr_i = 1'b0;
    logic [3:0] cpu_wr_code_i = 4'b0000;
    logic [3:0] code_o;
    logic       locked_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    logic [3:0] m_base = 4'b0000;
    logic       m_busy = 1'b0;
    logic       m_lock = 1'b0;
    logic       m_cons = 1'b0;

    always #2.5 clk = ~clk;

    mbx_rx_status dut (
        .clk(clk), .rst_n(rst_n),
        .store_start_i(store_start_i), .store_done_i(store_done_i),
        .cpu_read_i(cpu_read_i), .cpu_unlock_i(cpu_unlock_i),
        .cpu_wr_i(cpu_wr_i), .cpu_wr_code_i(cpu_wr_code_i),
        .code_o(code_o), .locked_o(locked_o)
    );

    function automatic logic legal_code(input logic [3:0] c);
        return c == 4'b0000 || c == 4'b0100 || c == 4'b0010 || c == 4'b0110;
    endfunction

    function automatic logic [3:0] exp_code();
        return {m_base[3:1], m_busy};
    endfunction

    task automatic model_step(input logic st, input logic dn, input logic rd,
                              input logic ul, input logic wr, input logic [3:0] wc);
        logic fin;
        fin = dn && m_busy;
        if (st && !m_busy && m_base != 4'b0000) begin
            m_busy = 1'b1;
        end else if (fin) begin
            m_busy = 1'b0;
            m_base = (m_base == 4'b0100 || (m_cons && !m_lock)) ? 4'b0010 : 4'b0110;
        end else if (wr && !m_busy && !st && legal_code(wc)) begin
            m_base = wc;
        end
        if (rd) m_lock = 1'b1;
        else if (ul) begin
            if (m_lock) m_cons = 1'b1;
            m_lock = 1'b0;
        end
        if (fin) m_cons = 1'b0;
    endtask

    task automatic check(input string tag, input logic [3:0] exp_c, input logic exp_l);
        n_chk++;
        if (code_o !== exp_c || locked_o !== exp_l) begin
            n_bad++;
            $display("FAIL %s: code=%b locked=%b, expected code=%b locked=%b",
                     tag, code_o, locked_o, exp_c, exp_l);
        end
    endtask

    task automatic step(input string tag, input logic st, input logic dn, input logic rd,
                        input logic ul, input logic wr, input logic [3:0] wc);
        store_start_i = st; store_done_i = dn; cpu_read_i = rd;
        cpu_unlock_i = ul; cpu_wr_i = wr; cpu_wr_code_i = wc;
        @(posedge clk);
        model_step(st, dn, rd, ul, wr, wc);
        @(negedge clk);
        store_start_i = 0; store_done_i = 0; cpu_read_i = 0;
        cpu_unlock_i = 0; cpu_wr_i = 0;
        check(tag, exp_code(), m_lock);
    endtask

    // directed step with an expected code stated from the requirement
    task automatic dstep(input string tag, input logic st, input logic dn, input logic rd,
                         input logic ul, input logic wr, input logic [3:0] wc,
                         input logic [3:0] want);
        step(tag, st, dn, rd, ul, wr, wc);
        n_chk++;
        if (code_o !== want) begin
            n_bad++;
            $display("FAIL %s: code=%b, expected %b", tag, code_o, want);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 4'b0000, 1'b0);

        dstep("R2", 1, 0, 0, 0, 0, 4'h0, 4'b0000);
        dstep("R2", 0, 1, 0, 0, 0, 4'h0, 4'b0000);
        dstep("R9", 0, 0, 0, 0, 1, 4'b0100, 4'b0100);
        dstep("R3", 1, 0, 0, 0, 0, 4'h0, 4'b0101);
        dstep("R3", 0, 0, 0, 0, 0, 4'h0, 4'b0101);
        dstep("R4", 0, 1, 0, 0, 0, 4'h0, 4'b0010);
        dstep("R3", 1, 0, 0, 0, 0, 4'h0, 4'b0011);
        dstep("R5", 0, 1, 0, 0, 0, 4'h0, 4'b0110);
        dstep("R3", 1, 0, 0, 0, 0, 4'h0, 4'b0111);
        dstep("R6", 0, 1, 0, 0, 0, 4'h0, 4'b0110);
        dstep("R8", 0, 0, 1, 0, 0, 4'h0, 4'b0110);
        check("R8", 4'b0110, 1'b1);
        dstep("R8", 0, 0, 0, 1, 0, 4'h0, 4'b0110);
        check("R8", 4'b0110, 1'b0);
        dstep("R7", 1, 0, 0, 0, 0, 4'h0, 4'b0111);
        dstep("R7", 0, 1, 0, 0, 0, 4'h0, 4'b0010);
        dstep("R7", 1, 0, 0, 0, 0, 4'h0, 4'b0011);
        dstep("R7", 0, 1, 0, 0, 0, 4'h0, 4'b0110);
        dstep("R8", 0, 0, 1, 0, 0, 4'h0, 4'b0110);
        dstep("R8", 0, 0, 0, 1, 0, 4'h0, 4'b0110);
        dstep("R8", 0, 0, 1, 0, 0, 4'h0, 4'b0110);
        dstep("R8", 1, 0, 0, 0, 0, 4'h0, 4'b0111);
        dstep("R8", 0, 1, 0, 0, 0, 4'h0, 4'b0110);
        dstep("R8", 0, 0, 0, 1, 0, 4'h0, 4'b0110);
        dstep("R10", 1, 0, 0, 0, 0, 4'h0, 4'b0111);
        dstep("R10", 1, 0, 0, 0, 0, 4'h0, 4'b0111);
        dstep("R9", 0, 0, 0, 0, 1, 4'b0100, 4'b0111);
        dstep("R7", 0, 1, 0, 0, 0, 4'h0, 4'b0010);
        dstep("R10", 0, 1, 0, 0, 0, 4'h0, 4'b0010);
        dstep("R9", 0, 0, 0, 0, 1, 4'b1000, 4'b0010);
        dstep("R9", 1, 0, 0, 0, 1, 4'b0100, 4'b0011);
        dstep("R4", 0, 1, 0, 0, 0, 4'h0, 4'b0110);
        dstep("R9", 0, 0, 0, 0, 1, 4'b0000, 4'b0000);
        dstep("R2", 1, 0, 0, 0, 0, 4'h0, 4'b0000);

        for (int i = 0; i < 3000; i++) begin
            logic st, dn, rd, ul, wr;
            logic [3:0] wc;
            int pick;
            string tag;
            st = ($urandom % 5) == 0;
            dn = m_busy ? (($urandom % 3) == 0) : (($urandom % 12) == 0);
            rd = ($urandom % 6) == 0;
            ul = ($urandom % 5) == 0;
            wr = ($urandom % 10) == 0;
            pick = $urandom % 6;
            case (pick)
                0, 1: wc = 4'b0100;
                2:    wc = 4'b0000;
                3:    wc = 4'b0010;
                4:    wc = 4'b0110;
                default: wc = 4'b1001;
            endcase
            if (dn && m_busy) tag = (m_base == 4'b0100) ? "R4" : (m_lock ? "R8" : "R7");
            else if (m_base == 4'b0000) tag = "R2";
            else if (wr) tag = "R9";
            else if (st && m_busy) tag = "R10";
            else tag = "R3";
            step(tag, st, dn, rd, ul, wr, wc);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule